// File: doc/BRIEF.md
# MSI Doorbell to Interrupt Line Frame

This block is a small memory-mapped frame that turns message-signaled interrupt writes into edge pulses on a parallel vector of shared peripheral interrupt lines. It owns a contiguous window of interrupt numbers, `BASE_INT` up to `BASE_INT+LINE_CNT-1`. Bit `k` of the output vector stands for interrupt number `BASE_INT+k`.

A bus master writes a data word to the doorbell register. The frame decodes the word into an interrupt number under the encoding selected by `mode_i`. If the number falls inside the window, the frame raises the matching output bit for exactly one clock cycle. If it falls outside, the frame drops the write and latches a sticky error flag.

Three read-only registers describe the frame: a type register holding the window base and count, a status register holding the error flag, and an identification register holding a fixed code. A downstream distributor sees every message as a rising edge, never as a level.

Top module: `msi_spi_frame`

## Requirements
- R1: A read of offset 0x008 returns the window base in bits [25:16] and the line count in bits [9:0]; every other bit reads as zero.
- R2: A read of offset 0xFCC returns the parameter `IMPL_ID`.
- R3: A read of the doorbell offset 0x040, or of any offset not listed here, returns zero.
- R4: When `mode_i`=0, doorbell data N with BASE_INT <= N < BASE_INT+LINE_CNT pulses output bit N-BASE_INT. The pulse appears in the cycle after the write is accepted.
- R5: When `mode_i`=1, doorbell data k with k < LINE_CNT pulses output bit k.
- R6: When `mode_i`=2, doorbell data d is taken as interrupt number d+32 and pulses bit d+32-BASE_INT when that number lies in the window.
- R7: A doorbell write whose decoded number lies outside the window, or any doorbell write while `mode_i`=3, produces no pulse. It sets bit 0 of the status register at offset 0x010, and that bit stays set until reset.
- R8: Each accepted doorbell write drives one output bit high for exactly one cycle, and at most one bit is high at a time. Doorbell writes in consecutive cycles produce consecutive pulses, one per write.
- R9: Writes to the type, status and identification offsets change no register, raise no pulse and set no error.
- R10: A read request is answered one cycle later: `rvalid_o` is high for that one cycle and `rdata_o` holds the data.
- R11: After reset the output vector is zero, `rvalid_o` is low and the error flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Doorbell data encoding: 0 absolute, 1 offset from base, 2 absolute minus 32, 3 reject all |
| req_i | input | 1 | Bus request, valid for one cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | ADDR_W (12) | Byte offset within the frame |
| wdata_i | input | DATA_W (32) | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DATA_W (32) | Read data |
| irq_o | output | LINE_CNT (16) | One-hot edge pulses, bit k for interrupt BASE_INT+k |

## Verification
The assertions assume that `mode_i` is a static setting: it is changed only in cycles with no doorbell write. They also assume that every bus request lasts a single cycle, so each write maps to one expected pulse. The stimulus meets both assumptions by changing the mode only inside idle cycles and by driving every request for exactly one clock. The bench never writes the same line twice in a row, so each pulse can be seen as its own edge. It checks that the error flag stays clear before the first out-of-window write, because the flag cannot be cleared without a reset.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

  localparam int unsigned OFS_TYPE     = 'h008;
  localparam int unsigned OFS_STATUS   = 'h010;
  localparam int unsigned OFS_DOORBELL = 'h040;
  localparam int unsigned OFS_IDENT    = 'hFCC;

  localparam int unsigned SPI_FLOOR = 32;
  localparam int unsigned SPI_CEIL  = 1019;

  typedef enum logic [1:0] {
    ENC_ABS   = 2'd0,
    ENC_REL   = 2'd1,
    ENC_SUB32 = 2'd2,
    ENC_RSVD  = 2'd3
  } enc_mode_e;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_TYPE   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_IDENT  = 2'd3
  } rd_sel_e;

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_frame_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rd_sel_e           rd_sel_o,
  output logic              is_doorbell_o
);

  always_comb begin
    rd_sel_o = SEL_NONE;
    if (addr_i == ADDR_W'(OFS_TYPE))        rd_sel_o = SEL_TYPE;
    else if (addr_i == ADDR_W'(OFS_STATUS)) rd_sel_o = SEL_STATUS;
    else if (addr_i == ADDR_W'(OFS_IDENT))  rd_sel_o = SEL_IDENT;
  end

  assign is_doorbell_o = (addr_i == ADDR_W'(OFS_DOORBELL));

endmodule

// File: rtl/msi_num_decode.sv
module msi_num_decode
  import msi_frame_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BASE_INT = 48,
  parameter int unsigned LINE_CNT = 16,
  localparam int unsigned IDX_W   = (LINE_CNT > 1) ? $clog2(LINE_CNT) : 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  enc_mode_e         mode_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hit_o
);

  localparam logic [DATA_W:0] LO = (DATA_W+1)'(BASE_INT);
  localparam logic [DATA_W:0] HI = (DATA_W+1)'(BASE_INT + LINE_CNT);

  logic [DATA_W:0] num;
  logic            mode_ok;

  // widen by one bit so adding the offset cannot wrap into the window
  always_comb begin
    mode_ok = 1'b1;
    unique case (mode_i)
      ENC_ABS:   num = {1'b0, data_i};
      ENC_REL:   num = {1'b0, data_i} + LO;
      ENC_SUB32: num = {1'b0, data_i} + (DATA_W+1)'(SPI_FLOOR);
      default: begin
        num     = '0;
        mode_ok = 1'b0;
      end
    endcase
  end

  assign hit_o = mode_ok && (num >= LO) && (num < HI);
  assign idx_o = IDX_W'(num - LO);

endmodule

// File: rtl/msi_pulse_gen.sv
module msi_pulse_gen #(
  parameter int unsigned LINE_CNT = 16,
  localparam int unsigned IDX_W   = (LINE_CNT > 1) ? $clog2(LINE_CNT) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fire_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [LINE_CNT-1:0] irq_o
);

  for (genvar g = 0; g < LINE_CNT; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o[g] <= 1'b0;
      else         irq_o[g] <= fire_i && (idx_i == IDX_W'(g));
    end
  end

endmodule

// File: rtl/msi_spi_frame.sv
module msi_spi_frame
  import msi_frame_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BASE_INT = 48,
  parameter int unsigned LINE_CNT = 16,
  parameter logic [31:0] IMPL_ID  = 32'h0000_0A51
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                rvalid_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [LINE_CNT-1:0] irq_o
);

  localparam int unsigned IDX_W = (LINE_CNT > 1) ? $clog2(LINE_CNT) : 1;
  localparam logic [31:0] TYPE_VAL =
    {6'b0, 10'(BASE_INT), 6'b0, 10'(LINE_CNT)};

  rd_sel_e          rd_sel;
  logic             is_doorbell;
  logic [IDX_W-1:0] line_idx;
  logic             line_hit;
  logic             db_wr;
  logic             fire;
  logic             err_q;

  msi_reg_decode #(.ADDR_W(ADDR_W)) u_reg_decode (
    .addr_i       (addr_i),
    .rd_sel_o     (rd_sel),
    .is_doorbell_o(is_doorbell)
  );

  msi_num_decode #(
    .DATA_W  (DATA_W),
    .BASE_INT(BASE_INT),
    .LINE_CNT(LINE_CNT)
  ) u_num_decode (
    .data_i(wdata_i),
    .mode_i(enc_mode_e'(mode_i)),
    .idx_o (line_idx),
    .hit_o (line_hit)
  );

  assign db_wr = req_i && we_i && is_doorbell;
  assign fire  = db_wr && line_hit;

  msi_pulse_gen #(.LINE_CNT(LINE_CNT)) u_pulse_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(fire),
    .idx_i (line_idx),
    .irq_o (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 err_q <= 1'b0;
    else if (db_wr && !line_hit) err_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) begin
        unique case (rd_sel)
          SEL_TYPE:   rdata_o <= DATA_W'(TYPE_VAL);
          SEL_STATUS: rdata_o <= DATA_W'(err_q);
          SEL_IDENT:  rdata_o <= DATA_W'(IMPL_ID);
          default:    rdata_o <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/msi_frame_chk.sv
module msi_frame_chk
  import msi_frame_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BASE_INT = 48,
  parameter int unsigned LINE_CNT = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                rvalid_o,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [LINE_CNT-1:0] irq_o,
  input logic                err_q
);

  localparam logic [DATA_W-1:0] TYPE_VAL =
    DATA_W'({6'b0, 10'(BASE_INT), 6'b0, 10'(LINE_CNT)});

  logic db_wr;
  assign db_wr = req_i && we_i && (addr_i == ADDR_W'(OFS_DOORBELL));

  initial begin
    p_window_cfg: assert (BASE_INT >= SPI_FLOOR && LINE_CNT > 0 &&
                          BASE_INT + LINE_CNT <= SPI_CEIL);
  end

  p_type_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(OFS_TYPE)) |=> (rdata_o == TYPE_VAL));

  p_pulse_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> $past(db_wr));

  p_no_spurious_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !db_wr |=> (irq_o == '0));

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  p_err_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(db_wr));

  p_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));

  p_rvalid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  p_rvalid_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

endmodule

bind msi_spi_frame msi_frame_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .BASE_INT(BASE_INT),
  .LINE_CNT(LINE_CNT)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rvalid_o(rvalid_o),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .err_q   (err_q)
);

// File: tb/msi_spi_frame_bench.sv
module msi_spi_frame_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int BASE   = 48;
  localparam int LINES  = 16;
  localparam logic [31:0] ID = 32'h0000_0A51;

  localparam logic [11:0] A_TYPE = 12'h008;
  localparam logic [11:0] A_STAT = 12'h010;
  localparam logic [11:0] A_DB   = 12'h040;
  localparam logic [11:0] A_ID   = 12'hFCC;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode = 2'd0;
  logic              req = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic              rvalid;
  logic [DATA_W-1:0] rdata;
  logic [LINES-1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit err_exp = 1'b0;

  logic [LINES-1:0]  q_irq[$];
  logic              q_rv[$];
  logic [DATA_W-1:0] q_rd[$];
  string             q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_spi_frame #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_INT(BASE), .LINE_CNT(LINES), .IMPL_ID(ID)
  ) u_msi_spi_frame (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [LINES-1:0] want(input logic [1:0] m, input longint d);
    longint n;
    case (m)
      2'd0: n = d;
      2'd1: n = d + BASE;
      2'd2: n = d + 32;
      default: return '0;
    endcase
    if (n >= BASE && n < BASE + LINES) return LINES'(1) << (n - BASE);
    return '0;
  endfunction

  task automatic push(input logic [LINES-1:0] i, input logic v,
                      input logic [DATA_W-1:0] d, input string t);
    q_irq.push_back(i); q_rv.push_back(v); q_rd.push_back(d); q_tag.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      push('0, 1'b0, '0, "R8");
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    req = 1'b0; we = 1'b0; mode = m;
    push('0, 1'b0, '0, "R8");
  endtask

  task automatic wr(input logic [11:0] a, input logic [DATA_W-1:0] d, input string t);
    logic [LINES-1:0] e;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    e = (a == A_DB) ? want(mode, longint'(d)) : '0;
    if (a == A_DB && e == '0) err_exp = 1'b1;
    push(e, 1'b0, '0, t);
  endtask

  task automatic rd(input logic [11:0] a, input logic [DATA_W-1:0] e, input string t);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; wdata = '0;
    push('0, 1'b1, e, t);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q_irq.size() > 0) begin
        logic [LINES-1:0] ei;
        logic ev;
        logic [DATA_W-1:0] ed;
        string et;
        ei = q_irq.pop_front(); ev = q_rv.pop_front();
        ed = q_rd.pop_front(); et = q_tag.pop_front();
        checks++;
        if (irq !== ei || rvalid !== ev || (ev && rdata !== ed)) begin
          errors++;
          $display("FAIL %s irq=%h exp %h rvalid=%b exp %b rdata=%h exp %h",
                   et, irq, ei, rvalid, ev, rdata, ed);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    checks++;
    if (irq !== '0 || rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R11 irq=%h rvalid=%b exp 0 0", irq, rvalid);
    end
    rst_n = 1'b1;
    idle(2);
    rd(A_STAT, 32'd0, "R11");
    rd(A_TYPE, (32'(BASE) << 16) | 32'(LINES), "R1");
    rd(A_ID, ID, "R2");
    rd(A_DB, 32'd0, "R3");
    rd(12'h004, 32'd0, "R3");
    rd(12'h100, 32'd0, "R3");
    rd(A_TYPE, (32'(BASE) << 16) | 32'(LINES), "R10");
    idle(1);
    // R9 writes to read-only offsets
    wr(A_TYPE, 32'hFFFF_FFFF, "R9");
    wr(A_ID, 32'h1234_5678, "R9");
    wr(A_STAT, 32'h1, "R9");
    rd(A_TYPE, (32'(BASE) << 16) | 32'(LINES), "R9");
    rd(A_ID, ID, "R9");
    rd(A_STAT, 32'd0, "R9");
    // R4 absolute mode
    set_mode(2'd0);
    wr(A_DB, 32'(BASE), "R4");
    idle(1);
    wr(A_DB, 32'(BASE + LINES - 1), "R4");
    idle(1);
    for (int k = 0; k < LINES; k++) wr(A_DB, 32'(BASE + k), "R4");
    // R8 back-to-back distinct lines
    wr(A_DB, 32'(BASE + 2), "R8");
    wr(A_DB, 32'(BASE + 3), "R8");
    idle(2);
    // R5 offset mode
    set_mode(2'd1);
    wr(A_DB, 32'd0, "R5");
    wr(A_DB, 32'(LINES - 1), "R5");
    wr(A_DB, 32'd7, "R5");
    idle(1);
    // R6 minus-32 mode
    set_mode(2'd2);
    wr(A_DB, 32'(BASE - 32), "R6");
    wr(A_DB, 32'(BASE + LINES - 33), "R6");
    idle(1);
    rd(A_STAT, 32'd0, "R6");
    // R7 out-of-window and reserved mode
    set_mode(2'd0);
    wr(A_DB, 32'(BASE - 1), "R7");
    rd(A_STAT, {31'd0, err_exp}, "R7");
    wr(A_DB, 32'(BASE + LINES), "R7");
    wr(A_DB, 32'hFFFF_FFFF, "R7");
    set_mode(2'd1);
    wr(A_DB, 32'(LINES), "R7");
    set_mode(2'd2);
    wr(A_DB, 32'(BASE + LINES - 32), "R7");
    set_mode(2'd3);
    wr(A_DB, 32'(BASE), "R7");
    idle(1);
    rd(A_STAT, 32'd1, "R7");
    set_mode(2'd0);
    wr(A_DB, 32'(BASE + 5), "R7");
    rd(A_STAT, 32'd1, "R7");
    idle(3);
    wait (q_irq.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule